// File: doc/BRIEF.md
# Fault-Tolerant Switching-State Remapper for a Five-Level Clamped H-Bridge

This block sits between the modulator and the gate drivers of one single-phase, five-level, neutral-point-clamped H-bridge module. Every clock it receives a requested switching-state index (1 to 9) and four blown-fuse indications, one per clamping-diode fuse. It then drives eight registered gate signals, one per power switch. A blown fuse acts like an open clamping diode, so some redundant states can no longer produce their terminal voltage. Once the fault is identified, the block replaces each such state with another state that gives the same terminal level.

The fuse indications feed a four-state fault-mode machine. The states are `MODE_HEALTHY`, `MODE_UPPER_LOST` (a fuse of diode 1 or 2 has blown), `MODE_LOWER_LOST` (a fuse of diode 3 or 4 has blown) and `MODE_DUAL_LOST` (fuses of both groups have blown). The transitions are:

- HEALTHY→UPPER_LOST on an upper-group fuse alone.
- HEALTHY→LOWER_LOST on a lower-group fuse alone.
- HEALTHY→DUAL_LOST when both groups are seen in the same cycle.
- UPPER_LOST→DUAL_LOST on any lower-group fuse.
- LOWER_LOST→DUAL_LOST on any upper-group fuse.

The machine otherwise stays in its state, and DUAL_LOST is left only by reset. Requests are substituted according to the latched mode, encoded leg by leg into gate bits, and registered together with the index of the state actually applied.

Top module: `level_state_remap`

## Requirements
- R1: While synchronous reset `rst` is high, at the next rising edge `gate` becomes 8'hCC (the state-4 pattern), `applied_state` becomes 4, and `illegal_req` and `dual_fault` become 0.
- R2: The gate pattern follows the applied state with bit 7..0 = S11,S12,S13,S14,S21,S22,S23,S24. The patterns are: 1=C3, 2=C6, 3=63, 4=CC, 5=66, 6=33, 7=6C, 8=36, 9=3C (hex). `gate` and `applied_state` update at the rising edge that samples the request.
- R3: In `MODE_HEALTHY` every legal request is applied unchanged.
- R4: In `MODE_UPPER_LOST` request 3 is applied as 2, request 7 as 8, and request 5 as the selected zero state.
- R5: In `MODE_LOWER_LOST` request 2 is applied as 3, request 8 as 7, and request 5 as the selected zero state.
- R6: The zero state that replaces request 5 is 4 when `zero_alt` is 0 and 6 when `zero_alt` is 1.
- R7: Requests 1, 4, 6 and 9 are never substituted outside `MODE_DUAL_LOST`.
- R8: A fuse indication held high for a single cycle latches the fault mode. The mode affects requests from the following cycle onward; a request in the same cycle as the pulse still uses the old mode. Only reset returns the machine to `MODE_HEALTHY`.
- R9: With both fuse groups seen, `dual_fault` goes high one edge after the fuse sample and stays high. Every request sampled while it is high yields `gate` = 8'hCC and `applied_state` = 4.
- R10: A request index of 0 or above 9 leaves `gate` and `applied_state` unchanged (except in `MODE_DUAL_LOST`, where R9 applies). It also raises `illegal_req` for exactly the cycle after that request.
- R11: S13, S14, S21 and S22 are always the complements of S11, S12, S23 and S24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous reset, active high |
| req_state | input | 4 | Requested switching-state index, legal 1..9 |
| fuse_blown | input | 4 | Blown-fuse flags; bits 0,1 upper group (diodes 1,2), bits 2,3 lower group (diodes 3,4) |
| zero_alt | input | 1 | Zero-state choice for request 5: 0 selects 4, 1 selects 6 |
| gate | output | 8 | Registered gate drives, S11 at bit 7 down to S24 at bit 0 |
| applied_state | output | 4 | Registered index of the state actually applied |
| illegal_req | output | 1 | One-cycle flag for an out-of-range request |
| dual_fault | output | 1 | Fuses of both groups have blown; outputs forced to state 4 |

## Verification
The hardest situation to reach is the boundary of a fault-mode change. This includes the request that arrives in the same cycle as a one-cycle fuse pulse, and the passage from a single-group mode into the dual mode while requests keep flowing. The stimulus pulses a fuse together with a request that would be substituted. It then drops the fuse and sweeps all nine indices, zero-state choices and out-of-range codes. It later pulses the other group's fuse and finally both groups at once after a reset. A bench model of the mode machine predicts, per cycle, which mode governs each request.

// File: rtl/remap_pkg.sv
package remap_pkg;

    typedef enum logic [1:0] {
        MODE_HEALTHY    = 2'd0,
        MODE_UPPER_LOST = 2'd1,
        MODE_LOWER_LOST = 2'd2,
        MODE_DUAL_LOST  = 2'd3
    } fault_mode_e;

    typedef enum logic [1:0] {
        LEG_POS = 2'd0,
        LEG_MID = 2'd1,
        LEG_NEG = 2'd2
    } leg_pos_e;

    localparam int LEG_SW = 4;

    // Four switch gates of one leg, outer-top switch first.
    function automatic logic [LEG_SW-1:0] leg_bits(input leg_pos_e p);
        logic [LEG_SW-1:0] b;
        unique case (p)
            LEG_POS: b = 4'b1100;
            LEG_MID: b = 4'b0110;
            LEG_NEG: b = 4'b0011;
            default: b = 4'b0110;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/remap_fault_fsm.sv
module remap_fault_fsm
    import remap_pkg::*;
#(
    parameter int N_FUSE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_FUSE-1:0] fuse_blown,
    output fault_mode_e       mode
);
    localparam int HALF = N_FUSE / 2;

    fault_mode_e state_q, state_d;
    logic        upper_hit, lower_hit;

    assign upper_hit = |fuse_blown[HALF-1:0];
    assign lower_hit = |fuse_blown[N_FUSE-1:HALF];

    always_ff @(posedge clk) begin
        if (rst) state_q <= MODE_HEALTHY;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_HEALTHY: begin
                if (upper_hit && lower_hit) state_d = MODE_DUAL_LOST;
                else if (upper_hit)         state_d = MODE_UPPER_LOST;
                else if (lower_hit)         state_d = MODE_LOWER_LOST;
            end
            MODE_UPPER_LOST: if (lower_hit) state_d = MODE_DUAL_LOST;
            MODE_LOWER_LOST: if (upper_hit) state_d = MODE_DUAL_LOST;
            MODE_DUAL_LOST:  state_d = MODE_DUAL_LOST;
        endcase
    end

    assign mode = state_q;

    // R8: fault modes are sticky
    a_r8_dual_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_DUAL_LOST) |=> (state_q == MODE_DUAL_LOST));
    a_r8_upper_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_UPPER_LOST) |=> (state_q inside {MODE_UPPER_LOST, MODE_DUAL_LOST}));
    a_r8_lower_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_LOWER_LOST) |=> (state_q inside {MODE_LOWER_LOST, MODE_DUAL_LOST}));
    a_r8_pulse_latch: assert property (@(posedge clk) disable iff (rst)
        (|fuse_blown) |=> (state_q != MODE_HEALTHY));

endmodule

// File: rtl/remap_substitute.sv
module remap_substitute
    import remap_pkg::*;
#(
    parameter int STATE_W   = 4,
    parameter int MAX_STATE = 9
) (
    input  fault_mode_e        mode,
    input  logic [STATE_W-1:0] req_state,
    input  logic               zero_alt,
    output logic [STATE_W-1:0] eff_state,
    output logic               legal
);
    localparam logic [STATE_W-1:0] ZERO_A = STATE_W'(4);
    localparam logic [STATE_W-1:0] ZERO_B = STATE_W'(6);

    logic [STATE_W-1:0] zero_pick;

    assign legal     = (req_state != '0) && (req_state <= STATE_W'(MAX_STATE));
    assign zero_pick = zero_alt ? ZERO_B : ZERO_A;

    always_comb begin
        eff_state = req_state;
        unique case (mode)
            MODE_HEALTHY: eff_state = req_state;
            MODE_UPPER_LOST: begin
                case (req_state)
                    STATE_W'(3): eff_state = STATE_W'(2);
                    STATE_W'(5): eff_state = zero_pick;
                    STATE_W'(7): eff_state = STATE_W'(8);
                    default:     eff_state = req_state;
                endcase
            end
            MODE_LOWER_LOST: begin
                case (req_state)
                    STATE_W'(2): eff_state = STATE_W'(3);
                    STATE_W'(5): eff_state = zero_pick;
                    STATE_W'(8): eff_state = STATE_W'(7);
                    default:     eff_state = req_state;
                endcase
            end
            MODE_DUAL_LOST: eff_state = ZERO_A;
        endcase
    end

endmodule

// File: rtl/remap_gate_encode.sv
module remap_gate_encode
    import remap_pkg::*;
#(
    parameter int STATE_W = 4,
    parameter int N_LEGS  = 2
) (
    input  logic [STATE_W-1:0]       state_idx,
    output logic [LEG_SW*N_LEGS-1:0] gates
);
    localparam int GATE_W = LEG_SW * N_LEGS;

    leg_pos_e pos [N_LEGS];

    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        if (g == 0) begin : g_left
            always_comb begin
                case (state_idx)
                    STATE_W'(1), STATE_W'(2), STATE_W'(4): pos[g] = LEG_POS;
                    STATE_W'(6), STATE_W'(8), STATE_W'(9): pos[g] = LEG_NEG;
                    default:                               pos[g] = LEG_MID;
                endcase
            end
        end else begin : g_right
            always_comb begin
                case (state_idx)
                    STATE_W'(4), STATE_W'(7), STATE_W'(9): pos[g] = LEG_POS;
                    STATE_W'(1), STATE_W'(3), STATE_W'(6): pos[g] = LEG_NEG;
                    default:                               pos[g] = LEG_MID;
                endcase
            end
        end
        assign gates[GATE_W-1-LEG_SW*g -: LEG_SW] = leg_bits(pos[g]);
    end

endmodule

// File: rtl/level_state_remap.sv
module level_state_remap
    import remap_pkg::*;
#(
    parameter int STATE_W = 4,
    parameter int N_FUSE  = 4,
    parameter int N_LEGS  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [STATE_W-1:0]         req_state,
    input  logic [N_FUSE-1:0]          fuse_blown,
    input  logic                       zero_alt,
    output logic [LEG_SW*N_LEGS-1:0]   gate,
    output logic [STATE_W-1:0]         applied_state,
    output logic                       illegal_req,
    output logic                       dual_fault
);
    localparam int GATE_W = LEG_SW * N_LEGS;
    localparam logic [STATE_W-1:0] SAFE_STATE = STATE_W'(4);

    fault_mode_e         mode;
    logic [STATE_W-1:0]  eff_state;
    logic                legal;
    logic [GATE_W-1:0]   enc_gates;
    logic [GATE_W-1:0]   safe_gates;
    logic [GATE_W-1:0]   gate_q;
    logic [STATE_W-1:0]  applied_q;
    logic                illegal_q;

    remap_fault_fsm #(.N_FUSE(N_FUSE)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .fuse_blown (fuse_blown),
        .mode       (mode)
    );

    remap_substitute #(.STATE_W(STATE_W)) u_sub (
        .mode      (mode),
        .req_state (req_state),
        .zero_alt  (zero_alt),
        .eff_state (eff_state),
        .legal     (legal)
    );

    remap_gate_encode #(.STATE_W(STATE_W), .N_LEGS(N_LEGS)) u_enc (
        .state_idx (eff_state),
        .gates     (enc_gates)
    );

    remap_gate_encode #(.STATE_W(STATE_W), .N_LEGS(N_LEGS)) u_safe_enc (
        .state_idx (SAFE_STATE),
        .gates     (safe_gates)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q    <= safe_gates;
            applied_q <= SAFE_STATE;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= ~legal;
            if (legal || (mode == MODE_DUAL_LOST)) begin
                gate_q    <= enc_gates;
                applied_q <= eff_state;
            end
        end
    end

    assign gate          = gate_q;
    assign applied_state = applied_q;
    assign illegal_req   = illegal_q;
    assign dual_fault    = (mode == MODE_DUAL_LOST);

    // R3: healthy mode passes legal requests through
    a_r3_pass_healthy: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HEALTHY && legal) |=> (applied_state == $past(req_state)));
    // R4: upper-group loss never applies 3, 5 or 7
    a_r4_upper_avoid: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_UPPER_LOST && legal) |=> !(applied_state inside {4'd3, 4'd5, 4'd7}));
    // R5: lower-group loss never applies 2, 5 or 8
    a_r5_lower_avoid: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOWER_LOST && legal) |=> !(applied_state inside {4'd2, 4'd5, 4'd8}));
    // R7: non-redundant states kept
    a_r7_keep_fixed: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_DUAL_LOST && (req_state inside {4'd1, 4'd4, 4'd6, 4'd9}))
        |=> (applied_state == $past(req_state)));
    // R9: dual fault forces state 4
    a_r9_dual_safe: assert property (@(posedge clk) disable iff (rst)
        dual_fault |=> (applied_state == SAFE_STATE && gate == 8'hCC));
    // R10: illegal request holds the outputs and flags
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!legal && mode != MODE_DUAL_LOST) |=> ($stable(gate) && $stable(applied_state) && illegal_req));
    a_r10_flag_clear: assert property (@(posedge clk) disable iff (rst)
        legal |=> !illegal_req);
    // R11: complementary switch pairs
    a_r11_complement: assert property (@(posedge clk) disable iff (rst)
        (gate[5] == ~gate[7]) && (gate[4] == ~gate[6]) &&
        (gate[3] == ~gate[1]) && (gate[2] == ~gate[0]));

endmodule

// File: tb/sim_level_state_remap.sv
module sim_level_state_remap;

    typedef struct {
        int         cyc;
        logic [7:0] g;
        logic [3:0] a;
        logic       il;
        logic       du;
        string      rq;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req_state = 4'd4;
    logic [3:0] fuse_blown = 4'd0;
    logic       zero_alt = 1'b0;
    logic [7:0] gate;
    logic [3:0] applied_state;
    logic       illegal_req;
    logic       dual_fault;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    done    = 0;
    item_t q[$];

    // model state: 0 healthy, 1 upper lost, 2 lower lost, 3 dual
    int         m_mode = 0;
    logic [7:0] m_gate = 8'hCC;
    logic [3:0] m_app  = 4'd4;

    level_state_remap u0 (
        .clk           (clk),
        .rst           (rst),
        .req_state     (req_state),
        .fuse_blown    (fuse_blown),
        .zero_alt      (zero_alt),
        .gate          (gate),
        .applied_state (applied_state),
        .illegal_req   (illegal_req),
        .dual_fault    (dual_fault)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pattern(input logic [3:0] s);
        case (s)
            4'd1: return 8'hC3;
            4'd2: return 8'hC6;
            4'd3: return 8'h63;
            4'd4: return 8'hCC;
            4'd5: return 8'h66;
            4'd6: return 8'h33;
            4'd7: return 8'h6C;
            4'd8: return 8'h36;
            default: return 8'h3C;
        endcase
    endfunction

    function automatic logic [3:0] expect_state(input int md, input logic [3:0] r, input logic za);
        logic [3:0] z;
        z = za ? 4'd6 : 4'd4;
        if (md == 3) return 4'd4;
        if (md == 1) begin
            if (r == 4'd3) return 4'd2;
            if (r == 4'd5) return z;
            if (r == 4'd7) return 4'd8;
        end
        if (md == 2) begin
            if (r == 4'd2) return 4'd3;
            if (r == 4'd5) return z;
            if (r == 4'd8) return 4'd7;
        end
        return r;
    endfunction

    task automatic check(input string rq, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] r, input logic [3:0] f, input logic za, input string rq);
        item_t it;
        bit lg, up, lo;
        @(negedge clk);
        req_state  = r;
        fuse_blown = f;
        zero_alt   = za;
        lg = (r >= 4'd1) && (r <= 4'd9);
        if (m_mode == 3 || lg) begin
            m_app  = expect_state(m_mode, r, za);
            m_gate = pattern(m_app);
        end
        up = |f[1:0];
        lo = |f[3:2];
        if (m_mode == 0) m_mode = (up && lo) ? 3 : up ? 1 : lo ? 2 : 0;
        else if (m_mode == 1 && lo) m_mode = 3;
        else if (m_mode == 2 && up) m_mode = 3;
        it.cyc = cyc;
        it.g   = m_gate;
        it.a   = m_app;
        it.il  = !lg;
        it.du  = (m_mode == 3);
        it.rq  = rq;
        q.push_back(it);
    endtask

    // monitor: compare results one edge after each request
    always @(negedge clk) begin
        if (!rst && q.size() > 0 && q[0].cyc < cyc) begin
            item_t it;
            it = q.pop_front();
            check(it.rq, "gate", gate, it.g);
            check(it.rq, "applied_state", applied_state, it.a);
            check(it.rq, "illegal_req", illegal_req, it.il);
            check(it.rq, "dual_fault", dual_fault, it.du);
            check("R11", "complement", {gate[5], gate[4], gate[3], gate[2]},
                  {~gate[7], ~gate[6], ~gate[1], ~gate[0]});
        end
    end

    task automatic do_reset;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        fuse_blown = 4'd0;
        req_state = 4'd9;
        repeat (2) @(negedge clk);
        check("R1", "gate", gate, 8'hCC);
        check("R1", "applied_state", applied_state, 4);
        check("R1", "illegal_req", illegal_req, 0);
        check("R1", "dual_fault", dual_fault, 0);
        rst = 1'b0;
        m_mode = 0;
        m_gate = 8'hCC;
        m_app  = 4'd4;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2 R3 R7: healthy sweep of all states
        for (int s = 1; s <= 9; s++) step(4'(s), 4'd0, 1'b0, "R2");
        for (int s = 9; s >= 1; s--) step(4'(s), 4'd0, 1'b1, "R3");
        // R10: out-of-range requests hold outputs
        step(4'd0,  4'd0, 1'b0, "R10");
        step(4'd12, 4'd0, 1'b0, "R10");
        step(4'd6,  4'd0, 1'b0, "R7");
        step(4'd15, 4'd0, 1'b0, "R10");
        // R8: single-cycle upper fuse pulse, same-cycle request unchanged
        step(4'd3, 4'b0001, 1'b0, "R8");
        // R4: upper-group substitution
        step(4'd3, 4'd0, 1'b0, "R4");
        step(4'd7, 4'd0, 1'b0, "R4");
        step(4'd5, 4'd0, 1'b0, "R4");
        step(4'd5, 4'd0, 1'b1, "R6");
        for (int s = 1; s <= 9; s++) step(4'(s), 4'd0, 1'b0, "R7");
        step(4'd11, 4'd0, 1'b0, "R10");
        // R9: lower fuse while upper lost -> dual
        step(4'd2, 4'b0100, 1'b0, "R9");
        step(4'd1, 4'd0, 1'b0, "R9");
        step(4'd9, 4'd0, 1'b1, "R9");
        step(4'd0, 4'd0, 1'b0, "R9");
        step(4'd3, 4'd0, 1'b0, "R9");
        // R8: reset clears the latched mode
        do_reset();
        step(4'd3, 4'd0, 1'b0, "R8");
        step(4'd5, 4'd0, 1'b0, "R8");
        // R5: lower-group substitution
        step(4'd8, 4'b1000, 1'b0, "R8");
        step(4'd2, 4'd0, 1'b0, "R5");
        step(4'd8, 4'd0, 1'b0, "R5");
        step(4'd5, 4'd0, 1'b0, "R5");
        step(4'd5, 4'd0, 1'b1, "R6");
        step(4'd3, 4'd0, 1'b0, "R5");
        step(4'd7, 4'd0, 1'b0, "R5");
        step(4'd1, 4'd0, 1'b0, "R7");
        step(4'd9, 4'd0, 1'b1, "R7");
        step(4'd13, 4'd0, 1'b0, "R10");
        step(4'd6, 4'b0010, 1'b0, "R9");
        step(4'd7, 4'd0, 1'b0, "R9");
        // R9: both groups in one cycle
        do_reset();
        step(4'd1, 4'b1111, 1'b0, "R9");
        step(4'd2, 4'd0, 1'b0, "R9");
        step(4'd8, 4'd0, 1'b0, "R9");
        repeat (3) @(negedge clk);
        while (q.size() > 0) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule